// File: doc/BRIEF.md
# Registered Function-Generator ALU Slice

This block is a cascadable ALU slice. It combines two operands under a 4-bit function select and a mode bit. In logic mode it produces one of sixteen bitwise functions of the two operands. In arithmetic mode it adds two select-chosen addends, each derived per bit from A and B, together with an active-low carry input. That gives sixteen arithmetic functions, each with and without carry: addition, subtraction, decrement, doubling and transfer among them.

Alongside the result, the slice drives three active-low outputs: a ripple carry out, a group propagate and a group generate. Wider words are built either by tying one slice's carry out to the next slice's carry in, or by feeding the group terms to an external lookahead unit.

An all-ones flag reports equality of the operands when the slice is set to subtract with no carry in. In that same setting, the carry out gives the relative magnitude of the operands. All outputs are registered once, and a synchronous active-high reset clears them.

Top module: `fgen_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the next state of the outputs is: `result` 0, `all_ones` 0, and `carry_out_n`, `grp_prop_n`, `grp_gen_n` all 1.
- R2: Every output reflects the inputs sampled at the previous rising clock edge. It does not change between edges.
- R3: With `logic_mode`=1, `fsel` values 0 through 15 give, in turn: ~A, ~(A|B), ~A&B, 0, ~(A&B), ~B, A^B, A&~B, ~A|B, ~(A^B), B, A&B, all ones, A|~B, A|B, A.
- R4: With `logic_mode`=1, `carry_in_n` has no effect on `result`.
- R5: With `logic_mode`=0 and `carry_in_n`=1, `result` is (X+Y) modulo 2^WIDTH. Per bit, X = A | (fsel[0]&B) | (fsel[1]&~B) and Y = A & ((fsel[3]&B) | (fsel[2]&~B)).
- R6: With `logic_mode`=0 and `carry_in_n`=0, `result` is (X+Y+1) modulo 2^WIDTH. So `fsel`=0110 gives A−B, 0011 gives 0, and 1111 gives A.
- R7: In both modes, `carry_out_n` is low exactly when X+Y+c reaches 2^WIDTH, where c = ~`carry_in_n`.
- R8: `grp_gen_n` is low exactly when X+Y reaches 2^WIDTH. `grp_prop_n` is low exactly when every bit of X is 1.
- R9: `all_ones` is high exactly when every `result` bit is 1. With `fsel`=0110, `logic_mode`=0 and `carry_in_n`=1, this means A equals B.
- R10: With `fsel`=0110 and `logic_mode`=0, a low `carry_out_n` means A>B when `carry_in_n`=1, and A≥B when `carry_in_n`=0.
- R11: The flattened lookahead variant (`FLAT_LOOKAHEAD`=1) and the ripple variant (0) give identical outputs for every input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| fsel | input | 4 | Function select |
| logic_mode | input | 1 | 1: bitwise functions, 0: arithmetic |
| carry_in_n | input | 1 | Carry input, low means carry present |
| result | output | WIDTH | Registered function result |
| carry_out_n | output | 1 | Registered carry out, active low |
| grp_prop_n | output | 1 | Registered group propagate, active low |
| grp_gen_n | output | 1 | Registered group generate, active low |
| all_ones | output | 1 | Registered flag: all result bits are 1 |

## Verification
The bench builds the slice at WIDTH=4 twice: once with the flattened lookahead and once with the ripple chain. At that width, every combination of operands, select, mode and carry input (16384 in all) can be swept against arithmetic reference values. This brings every carry boundary within reach, including the all-ones propagate case. It also covers every magnitude relation in subtract mode and the equality flag for each operand pair.

// File: rtl/fgen_alu_pkg.sv
package fgen_alu_pkg;

  localparam int SEL_W = 4;

  typedef logic [SEL_W-1:0] fsel_t;

  // select code that forms A + ~B (subtract / compare)
  localparam fsel_t SEL_SUB = 4'b0110;

  typedef struct packed {
    logic cout_n;
    logic prop_n;
    logic gen_n;
    logic eq;
  } alu_flags_t;

  localparam alu_flags_t FLAGS_IDLE = '{cout_n: 1'b1, prop_n: 1'b1, gen_n: 1'b1, eq: 1'b0};

endpackage

// File: rtl/fgen_alu_terms.sv
module fgen_alu_terms
  import fgen_alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  fsel_t            sel,
  output logic [WIDTH-1:0] prop,
  output logic [WIDTH-1:0] gen,
  output logic [WIDTH-1:0] half
);

  // per-bit addends: prop is the wide addend X, gen is the narrow addend Y
  // (gen implies prop, so X + Y never needs more than a carry per bit)
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign prop[i] = a[i] | (sel[0] & b[i]) | (sel[1] & ~b[i]);
    assign gen[i]  = a[i] & ((sel[3] & b[i]) | (sel[2] & ~b[i]));
    assign half[i] = prop[i] & ~gen[i];
  end

endmodule

// File: rtl/fgen_alu_lookahead.sv
module fgen_alu_lookahead #(
  parameter int WIDTH          = 4,
  parameter bit FLAT_LOOKAHEAD = 1'b1
) (
  input  logic [WIDTH-1:0] prop,
  input  logic [WIDTH-1:0] gen,
  input  logic             cin,
  output logic [WIDTH-1:0] carry,
  output logic             grp_p,
  output logic             grp_g,
  output logic             cout
);

  if (FLAT_LOOKAHEAD) begin : g_flat
    // every carry as an independent sum of products
    always_comb begin
      logic acc;
      logic run;
      for (int i = 0; i < WIDTH; i++) begin
        acc = 1'b0;
        run = 1'b1;
        for (int j = i - 1; j >= 0; j--) begin
          acc = acc | (run & gen[j]);
          run = run & prop[j];
        end
        carry[i] = acc | (run & cin);
      end
    end

    always_comb begin
      logic acc;
      logic run;
      acc = 1'b0;
      run = 1'b1;
      for (int j = WIDTH - 1; j >= 0; j--) begin
        acc = acc | (run & gen[j]);
        run = run & prop[j];
      end
      grp_g = acc;
    end
  end else begin : g_ripple
    logic [WIDTH-1:0] gchain;

    assign carry[0]  = cin;
    assign gchain[0] = gen[0];
    for (genvar i = 1; i < WIDTH; i++) begin : g_stage
      assign carry[i]  = gen[i-1] | (prop[i-1] & carry[i-1]);
      assign gchain[i] = gen[i] | (prop[i] & gchain[i-1]);
    end
    assign grp_g = gchain[WIDTH-1];
  end

  assign grp_p = &prop;
  assign cout  = grp_g | (grp_p & cin);

endmodule

// File: rtl/fgen_alu.sv
module fgen_alu
  import fgen_alu_pkg::*;
#(
  parameter int WIDTH          = 4,
  parameter bit FLAT_LOOKAHEAD = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [3:0]       fsel,
  input  logic             logic_mode,
  input  logic             carry_in_n,
  output logic [WIDTH-1:0] result,
  output logic             carry_out_n,
  output logic             grp_prop_n,
  output logic             grp_gen_n,
  output logic             all_ones
);

  logic [WIDTH-1:0] prop, gen, half, carry;
  logic             grp_p, grp_g, cout, cin;
  logic [WIDTH-1:0] f_nxt;
  alu_flags_t       flags_q;

  assign cin = ~carry_in_n;

  fgen_alu_terms #(.WIDTH(WIDTH)) u_terms (
    .a    (opa),
    .b    (opb),
    .sel  (fsel),
    .prop (prop),
    .gen  (gen),
    .half (half)
  );

  fgen_alu_lookahead #(.WIDTH(WIDTH), .FLAT_LOOKAHEAD(FLAT_LOOKAHEAD)) u_la (
    .prop  (prop),
    .gen   (gen),
    .cin   (cin),
    .carry (carry),
    .grp_p (grp_p),
    .grp_g (grp_g),
    .cout  (cout)
  );

  // logic mode forces the carries off and inverts the half sum
  assign f_nxt = logic_mode ? ~half : (half ^ carry);

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      flags_q <= FLAGS_IDLE;
    end else begin
      result  <= f_nxt;
      flags_q <= '{cout_n: ~cout, prop_n: ~grp_p, gen_n: ~grp_g, eq: &f_nxt};
    end
  end

  assign carry_out_n = flags_q.cout_n;
  assign grp_prop_n  = flags_q.prop_n;
  assign grp_gen_n   = flags_q.gen_n;
  assign all_ones    = flags_q.eq;

  // R7
  cout_from_groups_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (carry_out_n == ~(~grp_gen_n | (~grp_prop_n & ~$past(carry_in_n)))));

  // R9
  eq_on_compare_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(logic_mode) && $past(fsel) == SEL_SUB && $past(carry_in_n))
      |-> (all_ones == ($past(opa) == $past(opb))));

  // R10
  magnitude_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(logic_mode) && $past(fsel) == SEL_SUB)
      |-> (!carry_out_n == ($past(carry_in_n) ? ($past(opa) > $past(opb))
                                               : ($past(opa) >= $past(opb)))));

  // R4
  logic_cin_blind_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2) && $past(logic_mode) && $past(logic_mode, 2) &&
     $past(opa) == $past(opa, 2) && $past(opb) == $past(opb, 2) &&
     $past(fsel) == $past(fsel, 2)) |-> $stable(result));

  // R8
  gen_forces_carry_chk: assert property (@(posedge clk) disable iff (rst)
    !grp_gen_n |-> !carry_out_n);

endmodule

// File: tb/fgen_alu_test.sv
`timescale 1ns/1ps
module fgen_alu_test;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opa = '0, opb = '0;
  logic [3:0]   fsel = '0;
  logic         logic_mode = 1'b0, carry_in_n = 1'b1;
  logic [W-1:0] result, result_r;
  logic         cout_n, prop_n, gen_n, eq;
  logic         cout_n_r, prop_n_r, gen_n_r, eq_r;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  fgen_alu #(.WIDTH(W), .FLAT_LOOKAHEAD(1'b1)) uut (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .fsel(fsel),
    .logic_mode(logic_mode), .carry_in_n(carry_in_n),
    .result(result), .carry_out_n(cout_n), .grp_prop_n(prop_n),
    .grp_gen_n(gen_n), .all_ones(eq));

  fgen_alu #(.WIDTH(W), .FLAT_LOOKAHEAD(1'b0)) uut_rip (
    .clk(clk), .rst(rst), .opa(opa), .opb(opb), .fsel(fsel),
    .logic_mode(logic_mode), .carry_in_n(carry_in_n),
    .result(result_r), .carry_out_n(cout_n_r), .grp_prop_n(prop_n_r),
    .grp_gen_n(gen_n_r), .all_ones(eq_r));

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  // addend pair per select, written from the arithmetic function list
  function automatic void addends(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b,
                                  output logic [3:0] x, output logic [3:0] y);
    case (s)
      4'd0:  begin x = a;       y = 4'h0;   end // A
      4'd1:  begin x = a | b;   y = 4'h0;   end // A or B
      4'd2:  begin x = a | ~b;  y = 4'h0;   end // A or not B
      4'd3:  begin x = 4'hF;    y = 4'h0;   end // minus one
      4'd4:  begin x = a;       y = a & ~b; end
      4'd5:  begin x = a | b;   y = a & ~b; end
      4'd6:  begin x = a | ~b;  y = a & ~b; end // A + ~B
      4'd7:  begin x = 4'hF;    y = a & ~b; end
      4'd8:  begin x = a;       y = a & b;  end
      4'd9:  begin x = a | b;   y = a & b;  end // equals A + B
      4'd10: begin x = a | ~b;  y = a & b;  end
      4'd11: begin x = 4'hF;    y = a & b;  end
      4'd12: begin x = a;       y = a;      end // doubling
      4'd13: begin x = a | b;   y = a;      end
      4'd14: begin x = a | ~b;  y = a;      end
      default: begin x = 4'hF;  y = a;      end // A minus one
    endcase
  endfunction

  function automatic logic [3:0] logic_ref(input logic [3:0] s, input logic [3:0] a, input logic [3:0] b);
    case (s)
      4'd0:  return ~a;
      4'd1:  return ~(a | b);
      4'd2:  return ~a & b;
      4'd3:  return 4'h0;
      4'd4:  return ~(a & b);
      4'd5:  return ~b;
      4'd6:  return a ^ b;
      4'd7:  return a & ~b;
      4'd8:  return ~a | b;
      4'd9:  return ~(a ^ b);
      4'd10: return b;
      4'd11: return a & b;
      4'd12: return 4'hF;
      4'd13: return a | ~b;
      4'd14: return a | b;
      default: return a;
    endcase
  endfunction

  initial begin
    logic [7:0] prev;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1", "result", {4'h0, result}, 8'h00);
    chk("R1", "flags", {4'h0, cout_n, prop_n, gen_n, eq}, 8'h0E);
    prev = {result, cout_n, prop_n, gen_n, eq};
    rst = 1'b0;
    for (int m = 0; m < 2; m++) begin
      for (int cn = 0; cn < 2; cn++) begin
        for (int s = 0; s < 16; s++) begin
          for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
              logic [3:0] x, y, fe;
              logic [4:0] sum, gsum;
              logic       ce, pe, ge;
              string      freq;
              opa = a[3:0]; opb = b[3:0]; fsel = s[3:0];
              logic_mode = m[0]; carry_in_n = cn[0];
              #1;
              // R2: outputs hold until the next edge
              chk("R2", "hold", {result, cout_n, prop_n, gen_n, eq}, prev);
              @(negedge clk);
              addends(s[3:0], a[3:0], b[3:0], x, y);
              sum  = {1'b0, x} + {1'b0, y} + {4'h0, ~cn[0]};
              gsum = {1'b0, x} + {1'b0, y};
              if (m == 1) begin
                fe   = logic_ref(s[3:0], a[3:0], b[3:0]);
                freq = (cn == 0) ? "R4" : "R3";
              end else begin
                fe   = sum[3:0];
                freq = (cn == 0) ? "R6" : "R5";
              end
              ce = ~sum[4];
              ge = ~gsum[4];
              pe = ~(&x);
              chk(freq, "result", {4'h0, result}, {4'h0, fe});
              chk("R7", "carry_out_n", {7'h0, cout_n}, {7'h0, ce});
              chk("R8", "gen/prop", {6'h0, gen_n, prop_n}, {6'h0, ge, pe});
              chk("R9", "all_ones", {7'h0, eq}, {7'h0, &fe});
              if (m == 0 && s == 6) begin
                chk("R10", "magnitude", {7'h0, ~cout_n},
                    {7'h0, (cn == 1) ? (a > b) : (a >= b)});
                if (cn == 1) chk("R9", "equality", {7'h0, eq}, {7'h0, a == b});
              end
              chk("R11", "ripple variant", {result_r, cout_n_r, prop_n_r, gen_n_r},
                  {fe, ce, pe, ge});
              prev = {fe, ce, pe, ge, &fe};
            end
          end
        end
      end
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R2 watchdog: actual hung expected sweep complete");
      summary();
      $finish;
    end
  end

endmodule